// File: doc/BRIEF.md
# Run-Time Partitioned Lane Comparator

This block compares two operand words after splitting them into independent lanes, and it chooses the lane layout on every evaluation. Each operand is a row of equal-width chunks. Between each pair of neighbouring chunks there is one candidate boundary, and one gate input bit opens or closes it. The lanes are the longest runs of chunks that no open boundary crosses. Each lane is compared on its own.

A two-bit operation code chooses between equality, unsigned greater-than and unsigned greater-or-equal. Each lane gives a single result bit. That bit is copied into every output position the lane covers, and there is one output bit per chunk. This lets a downstream mask or select stage use the output directly at chunk granularity, whatever the lane widths are. The block is purely combinational.

Top module: `lane_cmp`

## Requirements
- R1: With operation code 0 (equality), each lane's result is 1 exactly when the two operand slices of that lane hold the same value.
- R2: With operation code 1, each lane's result is 1 exactly when the lane slice of `opa` is greater than that of `opb`, read as unsigned integers.
- R3: With operation code 2, each lane's result is 1 exactly when the lane slice of `opa` is greater than or equal to that of `opb`, read as unsigned integers.
- R4: Operation code 3 drives every output bit to 0, whatever the operands and gates are.
- R5: Gate bit i, when set, opens the boundary at operand bit position (i+1)*CHUNK_W, between chunk i and chunk i+1. When it is clear, those two chunks belong to the same lane.
- R6: Every output bit of a lane that spans several chunks carries the same value, and chunks of a wide lane rank with the higher chunk as more significant.
- R7: With all gate bits clear, the whole word is one lane, and every output bit equals one full-width comparison.
- R8: A change to the operand bits of one lane leaves the output bits of every other lane unchanged.
- R9: Output bit j belongs to chunk j, which holds operand bits j*CHUNK_W up to (j+1)*CHUNK_W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | CHUNK_W*NUM_CHUNKS | First operand word |
| opb | input | CHUNK_W*NUM_CHUNKS | Second operand word |
| gate | input | NUM_CHUNKS-1 | Boundary enables; bit i splits chunk i from chunk i+1 |
| op | input | 2 | Operation: 0 equal, 1 greater, 2 greater-or-equal, 3 none |
| result | output | NUM_CHUNKS | Per-chunk copy of the owning lane's compare result |

## Verification
The hardest case to reach is a multi-chunk greater-than decision that depends on carrying the outcome from a low chunk up through equal upper chunks. Random operands almost never make upper chunks equal. The stimulus therefore builds equal words on purpose, bumps or flips a single chunk, and forms `opa` as `opb + 1` so that the ripple path is used. Every one of these patterns is applied under every gate pattern of a four-chunk word and under every operation code.

// File: rtl/lane_cmp_pkg.sv
package lane_cmp_pkg;
    typedef enum logic [1:0] {
        CMP_EQ   = 2'd0,
        CMP_GT   = 2'd1,
        CMP_GE   = 2'd2,
        CMP_NONE = 2'd3
    } cmp_op_e;
endpackage

// File: rtl/lane_cmp_chunk.sv
module lane_cmp_chunk #(
    parameter int CHUNK_W    = 8,
    parameter int NUM_CHUNKS = 4,
    localparam int DATA_W    = CHUNK_W * NUM_CHUNKS
) (
    input  logic [DATA_W-1:0]     a,
    input  logic [DATA_W-1:0]     b,
    output logic [NUM_CHUNKS-1:0] eq,
    output logic [NUM_CHUNKS-1:0] gt
);
    // Local compare of each chunk on its own.
    for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_chunk
        logic [CHUNK_W-1:0] ca, cb;
        assign ca    = a[i*CHUNK_W +: CHUNK_W];
        assign cb    = b[i*CHUNK_W +: CHUNK_W];
        assign eq[i] = (ca == cb);
        assign gt[i] = (ca > cb);
    end
endmodule

// File: rtl/lane_cmp_merge.sv
module lane_cmp_merge #(
    parameter int NUM_CHUNKS = 4
) (
    input  logic [NUM_CHUNKS-1:0] eq,
    input  logic [NUM_CHUNKS-1:0] gt,
    input  logic [NUM_CHUNKS-2:0] gate,
    output logic [NUM_CHUNKS-1:0] eq_run,
    output logic [NUM_CHUNKS-1:0] gt_run
);
    // Ripple upward inside a lane: a higher chunk dominates, and ties
    // defer to the chunks below, until an open boundary is reached.
    always_comb begin
        eq_run[0] = eq[0];
        gt_run[0] = gt[0];
        for (int i = 1; i < NUM_CHUNKS; i++) begin
            eq_run[i] = eq[i] & (gate[i-1] | eq_run[i-1]);
            gt_run[i] = gt[i] | (eq[i] & ~gate[i-1] & gt_run[i-1]);
        end
    end
endmodule

// File: rtl/lane_cmp_spread.sv
module lane_cmp_spread
    import lane_cmp_pkg::*;
#(
    parameter int NUM_CHUNKS = 4
) (
    input  cmp_op_e               op,
    input  logic [NUM_CHUNKS-1:0] eq_run,
    input  logic [NUM_CHUNKS-1:0] gt_run,
    input  logic [NUM_CHUNKS-2:0] gate,
    output logic [NUM_CHUNKS-1:0] result
);
    logic [NUM_CHUNKS-1:0] pick;

    always_comb begin
        unique case (op)
            CMP_EQ:  pick = eq_run;
            CMP_GT:  pick = gt_run;
            CMP_GE:  pick = gt_run | eq_run;
            default: pick = '0;
        endcase
    end

    // The top chunk of each lane holds the lane verdict; copy it downward.
    always_comb begin
        result[NUM_CHUNKS-1] = pick[NUM_CHUNKS-1];
        for (int i = NUM_CHUNKS - 2; i >= 0; i--) begin
            result[i] = gate[i] ? pick[i] : result[i+1];
        end
    end
endmodule

// File: rtl/lane_cmp.sv
module lane_cmp
    import lane_cmp_pkg::*;
#(
    parameter int CHUNK_W    = 8,
    parameter int NUM_CHUNKS = 4,
    localparam int DATA_W    = CHUNK_W * NUM_CHUNKS
) (
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic [NUM_CHUNKS-2:0] gate,
    input  logic [1:0]            op,
    output logic [NUM_CHUNKS-1:0] result
);
    logic [NUM_CHUNKS-1:0] c_eq, c_gt, r_eq, r_gt;
    cmp_op_e               op_e;

    assign op_e = cmp_op_e'(op);

    lane_cmp_chunk #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)) u_chunk (
        .a(opa), .b(opb), .eq(c_eq), .gt(c_gt)
    );

    lane_cmp_merge #(.NUM_CHUNKS(NUM_CHUNKS)) u_merge (
        .eq(c_eq), .gt(c_gt), .gate(gate), .eq_run(r_eq), .gt_run(r_gt)
    );

    lane_cmp_spread #(.NUM_CHUNKS(NUM_CHUNKS)) u_spread (
        .op(op_e), .eq_run(r_eq), .gt_run(r_gt), .gate(gate), .result(result)
    );
endmodule

// File: rtl/lane_cmp_chk.sv
module lane_cmp_chk #(
    parameter int CHUNK_W    = 8,
    parameter int NUM_CHUNKS = 4,
    localparam int DATA_W    = CHUNK_W * NUM_CHUNKS
) (
    input logic [DATA_W-1:0]     opa,
    input logic [DATA_W-1:0]     opb,
    input logic [NUM_CHUNKS-2:0] gate,
    input logic [1:0]            op,
    input logic [NUM_CHUNKS-1:0] result
);
    always_comb begin
        // R4
        idle_zero_chk: assert (op != 2'd3 || result == '0);
        // R1
        equal_all_one_chk: assert (!(op == 2'd0 && opa == opb) || result == '1);
        // R7
        whole_gt_chk: assert (!(op == 2'd1 && gate == '0) || result == {NUM_CHUNKS{opa > opb}});
        // R7
        whole_ge_chk: assert (!(op == 2'd2 && gate == '0) || result == {NUM_CHUNKS{opa >= opb}});
        // R3
        ge_self_chk: assert (!(op == 2'd2 && opa == opb) || result == '1);
    end

    for (genvar i = 0; i < NUM_CHUNKS - 1; i++) begin : g_lane
        always_comb begin
            // R6
            lane_copy_chk: assert (gate[i] || result[i] == result[i+1]);
        end
    end
endmodule

bind lane_cmp lane_cmp_chk #(.CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)) u_lane_cmp_chk (
    .opa(opa), .opb(opb), .gate(gate), .op(op), .result(result)
);

// File: tb/lane_cmp_bench.sv
module lane_cmp_bench;
    localparam int CW = 8;
    localparam int NC = 4;
    localparam int DW = CW * NC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] opa, opb;
    logic [NC-2:0] gate;
    logic [1:0]    op;
    logic [NC-1:0] result;
    int            n_vec  = 0;
    int            n_fail = 0;
    bit            done   = 0;

    always #10 clk = ~clk;

    lane_cmp #(.CHUNK_W(CW), .NUM_CHUNKS(NC)) u_lane_cmp (
        .opa(opa), .opb(opb), .gate(gate), .op(op), .result(result)
    );

    function automatic logic [NC-1:0] model(logic [DW-1:0] a, logic [DW-1:0] b,
                                            logic [NC-2:0] g, logic [1:0] o);
        logic [NC-1:0] r;
        int lo;
        r  = '0;
        lo = 0;
        for (int c = 0; c < NC; c++) begin
            if (c == NC - 1 || g[c]) begin
                logic [63:0] mask, av, bv;
                logic bitv;
                mask = (64'd1 << ((c - lo + 1) * CW)) - 64'd1;
                av   = (64'(a) >> (lo * CW)) & mask;
                bv   = (64'(b) >> (lo * CW)) & mask;
                case (o)
                    2'd0:    bitv = (av == bv);
                    2'd1:    bitv = (av > bv);
                    2'd2:    bitv = (av >= bv);
                    default: bitv = 1'b0;
                endcase
                for (int k = lo; k <= c; k++) r[k] = bitv;
                lo = c + 1;
            end
        end
        return r;
    endfunction

    task automatic apply(input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic [NC-2:0] g, input logic [1:0] o,
                         input logic [NC-1:0] exp, input string tag);
        @(posedge clk);
        opa = a; opb = b; gate = g; op = o;
        @(negedge clk);
        n_vec++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h gate=%b op=%0d got %b expected %b",
                     tag, a, b, g, o, result, exp);
        end
    endtask

    function automatic string op_tag(logic [NC-2:0] g, logic [1:0] o);
        if (g == '0) return "R7";
        case (o)
            2'd0:    return "R1";
            2'd1:    return "R2";
            2'd2:    return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        opa = '0; opb = '0; gate = '0; op = 2'd0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // Reset state: zero operands, equality -> all ones (R1)
        @(negedge clk);
        n_vec++;
        if (result !== 4'b1111) begin
            n_fail++;
            $display("FAIL R1 reset: got %b expected 1111", result);
        end

        // Exhaustive gates x opcodes, shaped operand patterns
        for (int g = 0; g < (1 << (NC - 1)); g++) begin
            for (int o = 0; o < 4; o++) begin
                for (int p = 0; p < 16; p++) begin
                    logic [DW-1:0] a, b;
                    b = $urandom;
                    case (p % 4)
                        0: a = b;
                        1: a = b ^ (DW'(1) << ((p % NC) * CW + (p % CW)));
                        2: a = $urandom;
                        default: a = b + DW'(1);
                    endcase
                    if (p == 15) begin a = b; a[DW-1 -: CW] = b[DW-1 -: CW] + 8'd1; end
                    apply(a, b, (NC-1)'(g), 2'(o), model(a, b, (NC-1)'(g), 2'(o)),
                          op_tag((NC-1)'(g), 2'(o)));
                end
            end
        end

        // R4: opcode 3 with equal operands and all gates open
        apply(32'h1234_5678, 32'h1234_5678, 3'b111, 2'd3, 4'b0000, "R4");
        // R5/R6: boundary only at bit 8; low chunk a<b, upper lane a>b via chunk 1
        apply(32'h0000_0100, 32'h0000_0001, 3'b001, 2'd1, 4'b1110, "R5 R6");
        // R5: same operands, boundary closed -> one lane, a>b everywhere
        apply(32'h0000_0100, 32'h0000_0001, 3'b000, 2'd1, 4'b1111, "R5");
        // R9: every boundary open, only chunk 2 has a>b
        apply(32'h0055_0000, 32'h0044_0000, 3'b111, 2'd1, 4'b0100, "R9");
        // R8: lanes {0,1} and {2,3}; equal then upper lane raised
        apply(32'h1111_2222, 32'h1111_2222, 3'b010, 2'd1, 4'b0000, "R8");
        apply(32'h9111_2222, 32'h1111_2222, 3'b010, 2'd1, 4'b1100, "R8");
        apply(32'h9111_2222, 32'h1111_2222, 3'b010, 2'd0, 4'b0011, "R8");
        // R3: greater-or-equal across a wide lane with a tie in the upper chunk
        apply(32'h00FF_0000, 32'h00FF_0001, 3'b100, 2'd2, 4'b1000, "R3");
        // R2: equal words never greater
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b000, 2'd1, 4'b0000, "R2");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule